// File: doc/BRIEF.md
# Scan Chain Test Sequencer

This block runs structural stuck-at testing on one scan chain inside a small logic block. Test patterns arrive one at a time on a valid/ready input. Each pattern holds a chain load vector, an expected chain response, a don't-care mask, a value for the primary inputs, an expected primary-output value and a last-pattern flag. The sequencer raises scan enable and shifts the vector in one bit per cycle, through a per-cycle chain step enable. It then drops scan enable, drives the primary inputs, samples the primary outputs and fires exactly one capture step. After that it raises scan enable again and shifts the captured response out while the next vector shifts in on the same cycles.

Every bit leaving at scan-out is compared with the expected response, except where the mask marks it don't-care. After each unload a one-cycle result reports whether that pattern failed. A sticky flag keeps any failure until reset. The chain's contents before the first load are unknown, so the first unload of a run produces no result. A pattern flagged last is followed by one unload with no new vector, and then a one-cycle done pulse. Primary-input forcing and primary-output checking are each enabled by a parameter.

The controller has these states. S_IDLE waits for the first pattern of a run. S_LOAD shifts the vector in, and compares when a response is pending. S_FORCE drives the primary inputs. S_MEASURE samples the primary outputs. S_CAPTURE fires the single functional step. S_FETCH waits for the next pattern. S_UNLOAD is the final shift-out. S_DONE pulses done.

The transitions are:
- IDLE→LOAD on accept.
- LOAD→FORCE after the last shift.
- FORCE→MEASURE and MEASURE→CAPTURE unconditionally.
- CAPTURE→FETCH, or CAPTURE→UNLOAD when the pattern is flagged last.
- FETCH→LOAD on accept.
- UNLOAD→DONE after the last shift.
- DONE→IDLE.

Top module: `scan_seq`

## Requirements
- R1: After reset, pat_ready is 1, chain_step is 0, scan_en is 1, and res_valid, done and fail_sticky are 0.
- R2: Each load takes exactly CHAIN_LEN steps with scan_en high. Bit p of a vector is meant for flop p, where flop 0 is nearest scan-in and flop CHAIN_LEN-1 feeds scan_so. Bit CHAIN_LEN-1 is shifted first, so when capture fires, the chain holds the vector exactly.
- R3: Between the end of a load and the start of the next shift-out, there is exactly one step with scan_en low (the capture). In the cycle after it, scan_en is high again.
- R4: The response is unloaded on the same cycles that the next vector is loaded. Unload cycle k observes flop CHAIN_LEN-1-k and compares it with bit CHAIN_LEN-1-k of that pattern's expected response. One cycle after the last shift, res_valid pulses with res_fail set if any compared bit differed.
- R5: The unload that happens during the first load of a run is not compared. A run of P patterns therefore produces exactly P results.
- R6: A mask bit of 1 makes the matching response bit don't-care: a mismatch there never sets res_fail.
- R7: With FORCE_PI set, pi_drive carries the pattern's pat_pi value whenever scan_en is low (force, measure and capture), and is 0 whenever scan_en is high.
- R8: With MEASURE_PO set, po_in is sampled once after the load and before the capture. If it differs from pat_po_exp, that pattern's result fails.
- R9: After a pattern with pat_last set, one unload of CHAIN_LEN steps follows with no new vector. Then done pulses for one cycle, and pat_ready is 1 in the next cycle.
- R10: fail_sticky rises in the same cycle as the first failing result and stays 1 until reset.
- R11: A pattern is accepted only on a cycle with pat_valid and pat_ready both high. While pat_ready is high, chain_step is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pat_valid | input | 1 | Pattern offered |
| pat_ready | output | 1 | Sequencer can take a pattern |
| pat_vec | input | CHAIN_LEN | Chain load vector, bit p for flop p |
| pat_exp | input | CHAIN_LEN | Expected captured chain response |
| pat_mask | input | CHAIN_LEN | 1 marks a response bit don't-care |
| pat_pi | input | PI_W | Value forced on primary inputs |
| pat_po_exp | input | PO_W | Expected primary-output value |
| pat_last | input | 1 | Pattern is the last of the run |
| scan_en | output | 1 | 1 = shift, 0 = functional capture |
| scan_si | output | 1 | Bit presented at scan-in |
| scan_so | input | 1 | Bit from the flop nearest scan-out |
| chain_step | output | 1 | Chain clock enable for this cycle |
| pi_drive | output | PI_W | Primary-input drive |
| po_in | input | PO_W | Primary outputs of the logic under test |
| res_valid | output | 1 | Per-pattern result strobe |
| res_fail | output | 1 | Pattern failed (valid with res_valid) |
| fail_sticky | output | 1 | Any pattern failed since reset |
| done | output | 1 | One-cycle pulse after the final unload |

## Verification
The bench models the chain and its logic, and for each pattern computes the correct response and primary-output value. It then injects errors: some in masked bits, some in unmasked bits, some in the primary-output value. A sequencer that reversed the bit order, or lost one shift, would fail patterns that are good and load the wrong vector at capture. A sequencer that compared the first unload would report one result too many, caused by the random start-up contents of the chain. The bench also runs a single-pattern run, which takes the direct capture-to-unload path. A sequencer that skipped the final unload would never pulse done. One that kept scan enable high at capture would shift instead of capturing, and both the vector-at-capture check and the response check would catch it.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_FORCE,
        S_MEASURE,
        S_CAPTURE,
        S_FETCH,
        S_UNLOAD,
        S_DONE
    } seq_state_t;

endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
    import scan_seq_pkg::*;
#(
    parameter int CHAIN_LEN = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pat_valid,
    input  logic                          last_held,
    output seq_state_t                    state,
    output logic [$clog2(CHAIN_LEN)-1:0]  cnt,
    output logic                          pat_ready,
    output logic                          accept,
    output logic                          scan_en,
    output logic                          chain_step,
    output logic                          capture,
    output logic                          measure,
    output logic                          pi_active,
    output logic                          cmp_active,
    output logic                          last_shift,
    output logic                          done
);
    localparam int CW = $clog2(CHAIN_LEN);
    localparam logic [CW-1:0] LAST = CW'(CHAIN_LEN - 1);

    seq_state_t st, nxt;
    logic       cmp_on;
    logic       shifting;

    // state register, shift counter, compare-armed flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            cnt    <= '0;
            cmp_on <= 1'b0;
        end else begin
            st  <= nxt;
            cnt <= (shifting && cnt != LAST) ? cnt + 1'b1 : '0;
            if (st == S_IDLE && accept)
                cmp_on <= 1'b0;
            else if (st == S_CAPTURE)
                cmp_on <= 1'b1;
        end
    end

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:    if (pat_valid) nxt = S_LOAD;
            S_LOAD:    if (cnt == LAST) nxt = S_FORCE;
            S_FORCE:   nxt = S_MEASURE;
            S_MEASURE: nxt = S_CAPTURE;
            S_CAPTURE: nxt = last_held ? S_UNLOAD : S_FETCH;
            S_FETCH:   if (pat_valid) nxt = S_LOAD;
            S_UNLOAD:  if (cnt == LAST) nxt = S_DONE;
            S_DONE:    nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        state      = st;
        shifting   = (st == S_LOAD) || (st == S_UNLOAD);
        pat_ready  = (st == S_IDLE) || (st == S_FETCH);
        accept     = pat_ready && pat_valid;
        capture    = (st == S_CAPTURE);
        measure    = (st == S_MEASURE);
        pi_active  = (st == S_FORCE) || (st == S_MEASURE) || (st == S_CAPTURE);
        scan_en    = !pi_active;
        chain_step = shifting || capture;
        cmp_active = cmp_on && shifting;
        last_shift = shifting && (cnt == LAST);
        done       = (st == S_DONE);
    end

    // checker: count load shifts since the last capture
    logic [CW:0] load_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            load_seen <= '0;
        else if (chain_step && !scan_en)
            load_seen <= '0;
        else if (st == S_LOAD && load_seen != (CW+1)'(CHAIN_LEN))
            load_seen <= load_seen + 1'b1;
    end

    assert_load_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_step && !scan_en) |-> (load_seen == (CW+1)'(CHAIN_LEN)));
    assert_scan_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_step && !scan_en) |=> scan_en);
    assert_hold_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pat_ready |-> !chain_step);
    assert_ready_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (pat_ready && !done));

endmodule

// File: rtl/scan_seq_cmp.sv
module scan_seq_cmp (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_active,
    input  logic last_shift,
    input  logic so_bit,
    input  logic exp_bit,
    input  logic care_bit,
    input  logic po_check,
    input  logic po_mismatch,
    output logic res_valid,
    output logic res_fail,
    output logic fail_sticky
);
    logic acc;
    logic bit_mis;

    always_comb bit_mis = cmp_active && care_bit && (so_bit != exp_bit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc         <= 1'b0;
            res_valid   <= 1'b0;
            res_fail    <= 1'b0;
            fail_sticky <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (cmp_active && last_shift) begin
                res_valid   <= 1'b1;
                res_fail    <= acc || bit_mis;
                fail_sticky <= fail_sticky || acc || bit_mis;
                acc         <= 1'b0;
            end else if (bit_mis || (po_check && po_mismatch)) begin
                acc <= 1'b1;
            end
        end
    end

    assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fail_sticky |=> fail_sticky);
    assert_sticky_on_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fail) |-> fail_sticky);
    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

endmodule

// File: rtl/scan_seq.sv
module scan_seq
    import scan_seq_pkg::*;
#(
    parameter int CHAIN_LEN  = 9,
    parameter int PI_W       = 4,
    parameter int PO_W       = 4,
    parameter bit FORCE_PI   = 1'b1,
    parameter bit MEASURE_PO = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pat_valid,
    output logic                 pat_ready,
    input  logic [CHAIN_LEN-1:0] pat_vec,
    input  logic [CHAIN_LEN-1:0] pat_exp,
    input  logic [CHAIN_LEN-1:0] pat_mask,
    input  logic [PI_W-1:0]      pat_pi,
    input  logic [PO_W-1:0]      pat_po_exp,
    input  logic                 pat_last,
    output logic                 scan_en,
    output logic                 scan_si,
    input  logic                 scan_so,
    output logic                 chain_step,
    output logic [PI_W-1:0]      pi_drive,
    input  logic [PO_W-1:0]      po_in,
    output logic                 res_valid,
    output logic                 res_fail,
    output logic                 fail_sticky,
    output logic                 done
);
    localparam int CW = $clog2(CHAIN_LEN);
    localparam logic [CW-1:0] LAST = CW'(CHAIN_LEN - 1);

    seq_state_t          state;
    logic [CW-1:0]       cnt, idx;
    logic                accept, capture, measure, pi_active;
    logic                cmp_active, last_shift;
    logic                po_mis;

    logic [CHAIN_LEN-1:0] vec_r, nxt_exp, nxt_mask, chk_exp, chk_mask;
    logic [PI_W-1:0]      pi_r;
    logic [PO_W-1:0]      po_exp_r;
    logic                 last_r;

    scan_seq_ctrl #(.CHAIN_LEN(CHAIN_LEN)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pat_valid  (pat_valid),
        .last_held  (last_r),
        .state      (state),
        .cnt        (cnt),
        .pat_ready  (pat_ready),
        .accept     (accept),
        .scan_en    (scan_en),
        .chain_step (chain_step),
        .capture    (capture),
        .measure    (measure),
        .pi_active  (pi_active),
        .cmp_active (cmp_active),
        .last_shift (last_shift),
        .done       (done)
    );

    // pattern holding registers: new pattern on accept, response moves to check on capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_r    <= '0;
            nxt_exp  <= '0;
            nxt_mask <= '0;
            chk_exp  <= '0;
            chk_mask <= '0;
            pi_r     <= '0;
            po_exp_r <= '0;
            last_r   <= 1'b0;
        end else begin
            if (accept) begin
                vec_r    <= pat_vec;
                nxt_exp  <= pat_exp;
                nxt_mask <= pat_mask;
                pi_r     <= pat_pi;
                po_exp_r <= pat_po_exp;
                last_r   <= pat_last;
            end
            if (capture) begin
                chk_exp  <= nxt_exp;
                chk_mask <= nxt_mask;
            end
        end
    end

    // the flop farthest from scan-in is loaded first and unloaded first
    always_comb begin
        idx     = LAST - cnt;
        scan_si = (state == S_LOAD) ? vec_r[idx] : 1'b0;
    end

    generate
        if (FORCE_PI) begin : g_pi
            assign pi_drive = pi_active ? pi_r : '0;
        end else begin : g_no_pi
            assign pi_drive = '0;
        end
        if (MEASURE_PO) begin : g_po
            assign po_mis = (po_in != po_exp_r);
        end else begin : g_no_po
            assign po_mis = 1'b0;
        end
    endgenerate

    scan_seq_cmp u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_active  (cmp_active),
        .last_shift  (last_shift),
        .so_bit      (scan_so),
        .exp_bit     (chk_exp[idx]),
        .care_bit    (!chk_mask[idx]),
        .po_check    (measure),
        .po_mismatch (po_mis),
        .res_valid   (res_valid),
        .res_fail    (res_fail),
        .fail_sticky (fail_sticky)
    );

    assert_pi_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> (pi_drive == '0));

endmodule

// File: tb/scan_seq_tb.sv
module scan_seq_tb;
    localparam int N   = 9;
    localparam int PIW = 4;
    localparam int POW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic           pat_valid = 1'b0, pat_last = 1'b0;
    logic [N-1:0]   pat_vec = '0, pat_exp = '0, pat_mask = '0;
    logic [PIW-1:0] pat_pi = '0;
    logic [POW-1:0] pat_po_exp = '0;
    logic           pat_ready, scan_en, scan_si, scan_so, chain_step;
    logic [PIW-1:0] pi_drive;
    logic [POW-1:0] po_in;
    logic           res_valid, res_fail, fail_sticky, done;

    scan_seq #(.CHAIN_LEN(N), .PI_W(PIW), .PO_W(POW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pat_valid(pat_valid), .pat_ready(pat_ready),
        .pat_vec(pat_vec), .pat_exp(pat_exp), .pat_mask(pat_mask), .pat_pi(pat_pi),
        .pat_po_exp(pat_po_exp), .pat_last(pat_last), .scan_en(scan_en),
        .scan_si(scan_si), .scan_so(scan_so), .chain_step(chain_step),
        .pi_drive(pi_drive), .po_in(po_in), .res_valid(res_valid),
        .res_fail(res_fail), .fail_sticky(fail_sticky), .done(done)
    );

    // model of the logic under test
    function automatic logic [N-1:0] f_resp(logic [N-1:0] q, logic [PIW-1:0] pi);
        logic [N-1:0] r;
        for (int p = 0; p < N; p++)
            r[p] = q[(p + 1) % N] ^ (q[p] & pi[p % PIW]) ^ logic'(p % 2);
        return r;
    endfunction
    function automatic logic [POW-1:0] f_po(logic [N-1:0] q, logic [PIW-1:0] pi);
        return q[N-1 -: POW] ^ pi[POW-1:0];
    endfunction

    logic [N-1:0] chain = 9'h1A5;   // arbitrary start-up contents
    always @(posedge clk)
        if (chain_step)
            chain <= scan_en ? {chain[N-2:0], scan_si} : f_resp(chain, pi_drive);
    assign scan_so = chain[N-1];
    assign po_in   = f_po(chain, pi_drive);

    int errors = 0, checks = 0;
    int sent = 0, res_idx = 0, done_cnt = 0;
    bit exp_fail [64];
    bit any_fail = 1'b0;
    logic [N-1:0]   cur_vec = '0;
    logic [PIW-1:0] cur_pi = '0;
    bit prev_done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (pat_ready) chk(!chain_step, "R11 chain held while waiting", chain_step, 0);
            if (prev_done) chk(pat_ready, "R9 ready after done", pat_ready, 1);
            prev_done = done;
            if (done) done_cnt++;
            if (!scan_en) chk(pi_drive == cur_pi, "R7 pi forced", pi_drive, cur_pi);
            else          chk(pi_drive == '0, "R7 pi idle", pi_drive, 0);
            if (chain_step && !scan_en)
                chk(chain == cur_vec, "R2 R3 chain at capture", chain, cur_vec);
            if (res_valid) begin
                if (res_idx < sent) begin
                    any_fail = any_fail | exp_fail[res_idx];
                    chk(res_fail == exp_fail[res_idx], "R4 R6 R8 pattern result", res_fail, exp_fail[res_idx]);
                    chk(fail_sticky == any_fail, "R10 sticky", fail_sticky, any_fail);
                end else begin
                    chk(1'b0, "R5 extra result", res_idx, sent);
                end
                res_idx++;
            end
            if (pat_valid && pat_ready) begin
                cur_vec = pat_vec;
                cur_pi  = pat_pi;
            end
        end
    end

    // kind: 0 clean, 1 masked error, 2 unmasked error, 3 PO error, 4 all masked
    task automatic send(input int kind, input bit last);
        logic [N-1:0] v, r, e, m;
        logic [PIW-1:0] pi;
        logic [POW-1:0] po;
        int pos;
        repeat ($urandom % 3) @(negedge clk);
        v = N'($urandom); pi = PIW'($urandom);
        r = f_resp(v, pi); po = f_po(v, pi);
        e = r; m = '0;
        pos = $urandom % N;
        case (kind)
            1: begin m = N'(1) << pos; e = r ^ m; end
            2: begin e = r ^ (N'(1) << pos); m = N'($urandom) & ~(N'(1) << pos); end
            3: po = ~po;
            4: begin m = '1; e = N'($urandom); end
            default: m = N'($urandom) & N'($urandom);
        endcase
        exp_fail[sent] = (|((r ^ e) & ~m)) || (po != f_po(v, pi));
        sent++;
        @(negedge clk);
        pat_vec = v; pat_exp = e; pat_mask = m; pat_pi = pi; pat_po_exp = po;
        pat_last = last; pat_valid = 1'b1;
        while (!pat_ready) @(negedge clk);
        @(negedge clk);
        pat_valid = 1'b0;
    endtask

    task automatic finish_run();
        chk(1'b1, "", 0, 0);
        checks--;
        print_summary();
    endtask

    task automatic print_summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        print_summary();
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pat_ready == 1'b1, "R1 ready", pat_ready, 1);
        chk(chain_step == 1'b0, "R1 step", chain_step, 0);
        chk(scan_en == 1'b1, "R1 scan_en", scan_en, 1);
        chk(!res_valid && !done && !fail_sticky, "R1 flags", {res_valid, done, fail_sticky}, 0);

        // run A: directed kinds then random
        send(0, 0); send(1, 0); send(2, 0); send(3, 0);
        for (int i = 0; i < 8; i++) send($urandom % 5, i == 7);
        wait (done_cnt == 1);
        @(negedge clk);
        chk(res_idx == sent, "R5 R9 results after run A", res_idx, sent);

        // run B: single pattern, capture goes straight to final unload
        send(0, 1);
        wait (done_cnt == 2);
        @(negedge clk);
        chk(res_idx == sent, "R9 single-pattern run", res_idx, sent);

        // run C: fully masked patterns never fail
        for (int i = 0; i < 5; i++) send(4, i == 4);
        wait (done_cnt == 3);
        repeat (3) @(negedge clk);
        chk(res_idx == sent, "R5 one result per pattern", res_idx, sent);
        chk(done_cnt == 3, "R9 done pulses", done_cnt, 3);
        chk(fail_sticky == 1'b1, "R10 sticky held", fail_sticky, 1);
        finish_run();
    end
endmodule